// File: doc/BRIEF.md
# Write-Update Snooping Coherence Controller

This block keeps the coherence state and data for the lines of one private cache that shares a snooping bus with other caches. It follows a write-update discipline. When a processor writes a line that other caches also hold, the new word is broadcast on the bus and every other holder patches its own copy. No holder's copy is removed. Dirty data may be held by several caches at once. Exactly one of them is the owner that answers bus reads with its data, and the others stay clean relative to that owner.

Each line is in one of five states: empty, sole-clean, shared-clean, shared-owner or sole-dirty. The processor side presents one request per cycle (read, write or drop) on a word address. The upper address bits select the line and the lower bits select the word within it. A bus operation issued by this cache completes in the cycle it is raised. In that same cycle the bus returns the whole line on `fill_line` and the wired-OR sharing signal on `shared_in`. Transactions observed from other caches arrive on the snoop port. This cache answers them in the same cycle by driving the sharing signal and, for dirty data, a line flush.

Top module: `dragon_ctrl`

## Requirements
- R1: After reset every line is empty and all bus strobes (`bus_rd`, `bus_upd`, `flush`, `shared_out`) are low. The first read of any address therefore raises `bus_rd`.
- R2: A read (`req_op`=0) to an empty line raises `bus_rd` with `bus_addr`=`req_addr` and returns word `off` of `fill_line`, held in bits [off*WORD_W +: WORD_W]. The line becomes shared-clean if `shared_in` is high and sole-clean otherwise.
- R3: A read to a present line raises no bus strobe and returns the stored word.
- R4: A write (`req_op`=1) to an empty line raises `bus_rd` and fills the line with `req_wdata` merged in. If `shared_in` is high it also raises `bus_upd` with the address and word, and the line becomes the shared owner. Otherwise the line becomes sole-dirty and `bus_upd` stays low.
- R5: A write to a sole-clean or sole-dirty line updates the word with no bus strobe and leaves the line sole-dirty.
- R6: A write to a shared-clean or shared-owner line raises `bus_upd` carrying `req_addr` and `req_wdata`. The line becomes the shared owner if `shared_in` is high and sole-dirty otherwise.
- R7: A snooped bus read (`snp_op`=0) to a sole-dirty line raises `flush` with the whole line on `flush_data` (word k in bits [k*WORD_W +: WORD_W]) and moves the line to shared owner. On a shared-owner line it flushes the same way and the line stays shared owner.
- R8: A snooped bus read to a sole-clean line moves it to shared-clean without a flush. A shared-clean line stays shared-clean, also without a flush.
- R9: A snooped update (`snp_op`=1) to a shared-clean or shared-owner line writes `snp_wdata` into word `snp_addr` of the local copy at the clock edge and leaves the line shared-clean, with no flush.
- R10: `shared_out` is high in exactly the cycles where a snoop targets a present line.
- R11: A snoop to an empty line changes no state and raises neither `flush` nor `shared_out`.
- R12: A drop (`req_op`=2) empties the line. It raises `flush` with the line data when the line was sole-dirty or shared owner, and raises no flush otherwise.
- R13: A processor request in a cycle with `snp_valid` high is ignored. No bus strobe is raised for it and no state or data changes because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_op | input | 2 | 0 read, 1 write, 2 drop |
| req_addr | input | ADDR_W | Word address: line index above word offset |
| req_wdata | input | WORD_W | Write word |
| rsp_rdata | output | WORD_W | Read word (stored, or from fill on a miss) |
| fill_line | input | LINE_W | Line returned by the bus in a `bus_rd` cycle |
| shared_in | input | 1 | Wired-OR sharing signal from other caches |
| bus_rd | output | 1 | Bus read issued this cycle |
| bus_upd | output | 1 | Bus update issued this cycle |
| bus_addr | output | ADDR_W | Address of the issued bus operation |
| bus_wdata | output | WORD_W | Word carried by the bus update |
| snp_valid | input | 1 | Foreign bus transaction observed |
| snp_op | input | 1 | 0 bus read, 1 bus update |
| snp_addr | input | ADDR_W | Word address of the snooped transaction |
| snp_wdata | input | WORD_W | Word carried by a snooped update |
| shared_out | output | 1 | This cache holds the snooped line |
| flush | output | 1 | Line data driven to the bus |
| flush_data | output | LINE_W | Flushed line |

## Verification
The bound checker watches the following on every cycle:
- the snoop port always takes precedence over the processor request;
- hits and writes to a sole-clean line stay off the bus;
- each write, miss, snooped update or drop leaves the target line in its required state on the next edge;
- dirty lines always flush when a bus read is snooped.

The bench's reference model covers what the checker cannot see from one line's state alone: the data itself. This includes merged fill words, patched words from snooped updates, flushed line contents, and the sequences that show a state only through later behaviour, such as a drop followed by a fresh miss.

// File: rtl/dragon_pkg.sv
package dragon_pkg;

   typedef enum logic [2:0] {
      LS_NONE = 3'd0,
      LS_EXCL = 3'd1,
      LS_SCLN = 3'd2,
      LS_SOWN = 3'd3,
      LS_DRTY = 3'd4
   } line_st_e;

   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_DROP  = 2'd2,
      OP_NOP   = 2'd3
   } req_op_e;

   localparam logic SNP_RD  = 1'b0;
   localparam logic SNP_UPD = 1'b1;

   localparam int ST_W = 3;

endpackage

// File: rtl/dragon_next.sv
module dragon_next
   import dragon_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int WORDS  = 4,
   localparam int OFF_W  = $clog2(WORDS),
   localparam int LINE_W = WORD_W * WORDS
) (
   input  line_st_e             cur_st,
   input  logic [LINE_W-1:0]    cur_data,
   input  logic                 req_sel,
   input  req_op_e              req_op,
   input  logic [OFF_W-1:0]     req_off,
   input  logic [WORD_W-1:0]    req_wdata,
   input  logic [LINE_W-1:0]    fill_line,
   input  logic                 shared_in,
   input  logic                 snp_sel,
   input  logic                 snp_op,
   input  logic [OFF_W-1:0]     snp_off,
   input  logic [WORD_W-1:0]    snp_wdata,
   output line_st_e             nxt_st,
   output logic [LINE_W-1:0]    nxt_data,
   output logic                 want_rd,
   output logic                 want_upd,
   output logic                 want_flush
);

   logic present;
   assign present = (cur_st != LS_NONE);

   always_comb begin
      nxt_st     = cur_st;
      nxt_data   = cur_data;
      want_rd    = 1'b0;
      want_upd   = 1'b0;
      want_flush = 1'b0;
      if (snp_sel) begin
         if (present) begin
            if (snp_op == SNP_RD) begin
               unique case (cur_st)
                  LS_DRTY: begin nxt_st = LS_SOWN; want_flush = 1'b1; end
                  LS_SOWN: want_flush = 1'b1;
                  LS_EXCL: nxt_st = LS_SCLN;
                  default: ;
               endcase
            end else begin
               nxt_data[snp_off*WORD_W +: WORD_W] = snp_wdata;
               nxt_st = LS_SCLN;
            end
         end
      end else if (req_sel) begin
         unique case (req_op)
            OP_READ: begin
               if (!present) begin
                  want_rd  = 1'b1;
                  nxt_data = fill_line;
                  nxt_st   = shared_in ? LS_SCLN : LS_EXCL;
               end
            end
            OP_WRITE: begin
               if (!present) begin
                  want_rd  = 1'b1;
                  nxt_data = fill_line;
                  nxt_data[req_off*WORD_W +: WORD_W] = req_wdata;
                  want_upd = shared_in;
                  nxt_st   = shared_in ? LS_SOWN : LS_DRTY;
               end else begin
                  nxt_data[req_off*WORD_W +: WORD_W] = req_wdata;
                  if (cur_st == LS_SCLN || cur_st == LS_SOWN) begin
                     want_upd = 1'b1;
                     nxt_st   = shared_in ? LS_SOWN : LS_DRTY;
                  end else begin
                     nxt_st = LS_DRTY;
                  end
               end
            end
            OP_DROP: begin
               want_flush = (cur_st == LS_DRTY) || (cur_st == LS_SOWN);
               nxt_st     = LS_NONE;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/dragon_line.sv
module dragon_line
   import dragon_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int WORDS  = 4,
   localparam int OFF_W  = $clog2(WORDS),
   localparam int LINE_W = WORD_W * WORDS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_sel,
   input  req_op_e              req_op,
   input  logic [OFF_W-1:0]     req_off,
   input  logic [WORD_W-1:0]    req_wdata,
   input  logic [LINE_W-1:0]    fill_line,
   input  logic                 shared_in,
   input  logic                 snp_sel,
   input  logic                 snp_op,
   input  logic [OFF_W-1:0]     snp_off,
   input  logic [WORD_W-1:0]    snp_wdata,
   output line_st_e             st_q,
   output logic [LINE_W-1:0]    data_q,
   output logic                 want_rd,
   output logic                 want_upd,
   output logic                 want_flush
);

   line_st_e          st_d;
   logic [LINE_W-1:0] data_d;

   dragon_next #(.WORD_W(WORD_W), .WORDS(WORDS)) u_next (
      .cur_st     (st_q),
      .cur_data   (data_q),
      .req_sel    (req_sel),
      .req_op     (req_op),
      .req_off    (req_off),
      .req_wdata  (req_wdata),
      .fill_line  (fill_line),
      .shared_in  (shared_in),
      .snp_sel    (snp_sel),
      .snp_op     (snp_op),
      .snp_off    (snp_off),
      .snp_wdata  (snp_wdata),
      .nxt_st     (st_d),
      .nxt_data   (data_d),
      .want_rd    (want_rd),
      .want_upd   (want_upd),
      .want_flush (want_flush)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= LS_NONE;
         data_q <= '0;
      end else begin
         st_q   <= st_d;
         data_q <= data_d;
      end
   end

endmodule

// File: rtl/dragon_ctrl.sv
module dragon_ctrl
   import dragon_pkg::*;
#(
   parameter int WORD_W = 32,
   parameter int LINES  = 4,
   parameter int WORDS  = 4,
   localparam int IDX_W  = $clog2(LINES),
   localparam int OFF_W  = $clog2(WORDS),
   localparam int ADDR_W = IDX_W + OFF_W,
   localparam int LINE_W = WORD_W * WORDS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [1:0]           req_op,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [WORD_W-1:0]    req_wdata,
   output logic [WORD_W-1:0]    rsp_rdata,
   input  logic [LINE_W-1:0]    fill_line,
   input  logic                 shared_in,
   output logic                 bus_rd,
   output logic                 bus_upd,
   output logic [ADDR_W-1:0]    bus_addr,
   output logic [WORD_W-1:0]    bus_wdata,
   input  logic                 snp_valid,
   input  logic                 snp_op,
   input  logic [ADDR_W-1:0]    snp_addr,
   input  logic [WORD_W-1:0]    snp_wdata,
   output logic                 shared_out,
   output logic                 flush,
   output logic [LINE_W-1:0]    flush_data
);

   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("dragon_ctrl: LINES must be a power of two of at least 2");
   end
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("dragon_ctrl: WORDS must be a power of two of at least 2");
   end
   if (WORD_W < 1) begin : g_bad_width
      $error("dragon_ctrl: WORD_W must be positive");
   end

   logic [IDX_W-1:0] req_idx, snp_idx, fl_idx;
   logic [OFF_W-1:0] req_off, snp_off;
   logic             req_go;

   assign req_idx = req_addr[ADDR_W-1:OFF_W];
   assign req_off = req_addr[OFF_W-1:0];
   assign snp_idx = snp_addr[ADDR_W-1:OFF_W];
   assign snp_off = snp_addr[OFF_W-1:0];
   assign req_go  = req_valid && !snp_valid;
   assign fl_idx  = snp_valid ? snp_idx : req_idx;

   line_st_e          st_q      [LINES];
   logic [LINE_W-1:0] line_data [LINES];
   logic [LINES-1:0]  present, w_rd, w_upd, w_flush;
   logic [LINES*ST_W-1:0] st_flat;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      dragon_line #(.WORD_W(WORD_W), .WORDS(WORDS)) u_line (
         .clk        (clk),
         .rst_n      (rst_n),
         .req_sel    (req_go && (req_idx == IDX_W'(i))),
         .req_op     (req_op_e'(req_op)),
         .req_off    (req_off),
         .req_wdata  (req_wdata),
         .fill_line  (fill_line),
         .shared_in  (shared_in),
         .snp_sel    (snp_valid && (snp_idx == IDX_W'(i))),
         .snp_op     (snp_op),
         .snp_off    (snp_off),
         .snp_wdata  (snp_wdata),
         .st_q       (st_q[i]),
         .data_q     (line_data[i]),
         .want_rd    (w_rd[i]),
         .want_upd   (w_upd[i]),
         .want_flush (w_flush[i])
      );
      assign present[i]             = (st_q[i] != LS_NONE);
      assign st_flat[i*ST_W +: ST_W] = st_q[i];
   end

   logic [LINE_W-1:0] rd_src;

   always_comb begin
      rd_src     = present[req_idx] ? line_data[req_idx] : fill_line;
      rsp_rdata  = rd_src[req_off*WORD_W +: WORD_W];
      bus_rd     = |w_rd;
      bus_upd    = |w_upd;
      bus_addr   = req_addr;
      bus_wdata  = req_wdata;
      flush      = |w_flush;
      flush_data = flush ? line_data[fl_idx] : '0;
      shared_out = snp_valid && present[snp_idx];
   end

endmodule

// File: rtl/dragon_ctrl_chk.sv
module dragon_ctrl_chk
   import dragon_pkg::*;
#(
   parameter int LINES = 4,
   parameter int WORDS = 4,
   localparam int IDX_W  = $clog2(LINES),
   localparam int OFF_W  = $clog2(WORDS),
   localparam int ADDR_W = IDX_W + OFF_W
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic [1:0]            req_op,
   input logic [ADDR_W-1:0]     req_addr,
   input logic                  shared_in,
   input logic                  snp_valid,
   input logic                  snp_op,
   input logic [ADDR_W-1:0]     snp_addr,
   input logic                  bus_rd,
   input logic                  bus_upd,
   input logic                  flush,
   input logic                  shared_out,
   input logic [LINES*ST_W-1:0] st_flat
);

   logic [IDX_W-1:0] ridx, sidx;
   logic [ST_W-1:0]  rst_cur, sst_cur;
   logic             go;

   assign ridx    = req_addr[ADDR_W-1:OFF_W];
   assign sidx    = snp_addr[ADDR_W-1:OFF_W];
   assign rst_cur = st_flat[ridx*ST_W +: ST_W];
   assign sst_cur = st_flat[sidx*ST_W +: ST_W];
   assign go      = req_valid && !snp_valid;

   function automatic logic [ST_W-1:0] st_at(input logic [IDX_W-1:0] i,
                                            input logic [LINES*ST_W-1:0] v);
      return v[i*ST_W +: ST_W];
   endfunction

   p_snoop_blocks_req_r13: assert property (@(posedge clk) disable iff (!rst_n)
      snp_valid |-> (!bus_rd && !bus_upd));

   p_hit_read_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (go && req_op == 2'd0 && rst_cur != LS_NONE) |-> (!bus_rd && !bus_upd && !flush));

   p_miss_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (go && req_op == 2'd0 && rst_cur == LS_NONE) |=>
      (st_at($past(ridx), st_flat) == ($past(shared_in) ? LS_SCLN : LS_EXCL)));

   p_excl_write_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (go && req_op == 2'd1 && rst_cur == LS_EXCL) |-> (!bus_rd && !bus_upd));

   p_excl_write_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (go && req_op == 2'd1 && rst_cur == LS_EXCL) |=> (st_at($past(ridx), st_flat) == LS_DRTY));

   p_upd_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (go && req_op == 2'd1 && bus_upd) |=>
      (st_at($past(ridx), st_flat) == ($past(shared_in) ? LS_SOWN : LS_DRTY)));

   p_write_miss_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (go && req_op == 2'd1 && rst_cur == LS_NONE) |-> (bus_rd && (bus_upd == shared_in)));

   p_dirty_snoop_flush_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_op == SNP_RD && (sst_cur == LS_DRTY || sst_cur == LS_SOWN)) |-> flush);

   p_dirty_snoop_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_op == SNP_RD && (sst_cur == LS_DRTY || sst_cur == LS_SOWN)) |=>
      (st_at($past(sidx), st_flat) == LS_SOWN));

   p_snoop_upd_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && snp_op == SNP_UPD && sst_cur != LS_NONE) |=>
      (st_at($past(sidx), st_flat) == LS_SCLN));

   p_shared_needs_snoop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      shared_out |-> snp_valid);

   p_drop_empties_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (go && req_op == 2'd2) |=> (st_at($past(ridx), st_flat) == LS_NONE));

endmodule

bind dragon_ctrl dragon_ctrl_chk #(.LINES(LINES), .WORDS(WORDS)) u_chk (.*);

// File: tb/dragon_ctrl_tb.sv
`timescale 1ns/1ps
module dragon_ctrl_tb;

   localparam int WW = 32;
   localparam int NL = 4;
   localparam int NW = 4;
   localparam int AW = 4;
   localparam int LW = WW * NW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid;
   logic [1:0]    req_op;
   logic [AW-1:0] req_addr;
   logic [WW-1:0] req_wdata;
   logic [WW-1:0] rsp_rdata;
   logic [LW-1:0] fill_line;
   logic          shared_in;
   logic          bus_rd, bus_upd;
   logic [AW-1:0] bus_addr;
   logic [WW-1:0] bus_wdata;
   logic          snp_valid, snp_op;
   logic [AW-1:0] snp_addr;
   logic [WW-1:0] snp_wdata;
   logic          shared_out, flush;
   logic [LW-1:0] flush_data;

   always #2.5 clk = ~clk;

   dragon_ctrl #(.WORD_W(WW), .LINES(NL), .WORDS(NW)) u_dut (.*);

   int vectors = 0;
   int errors  = 0;

   // model states: 0 empty, 1 sole-clean, 2 shared-clean, 3 shared-owner, 4 sole-dirty
   int          mst  [NL];
   logic [WW-1:0] mdat [NL][NW];

   function automatic logic [LW-1:0] pack_line(input int l);
      logic [LW-1:0] r;
      for (int k = 0; k < NW; k++) r[k*WW +: WW] = mdat[l][k];
      return r;
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [LW-1:0] act, input logic [LW-1:0] exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic step(input bit v, input int op, input int a, input logic [WW-1:0] wd,
                       input bit sh, input bit sv, input int so, input int sa,
                       input logic [WW-1:0] sw, input string tag);
      logic [LW-1:0] fl;
      bit e_rd, e_upd, e_fl, e_sh, chk_rsp;
      logic [LW-1:0] e_fd;
      logic [WW-1:0] e_rsp;
      int li, lo, si, sof, tl, nst;
      logic [WW-1:0] nd [NW];
      @(negedge clk);
      fl = {$urandom, $urandom, $urandom, $urandom};
      req_valid = v; req_op = 2'(op); req_addr = AW'(a); req_wdata = wd;
      shared_in = sh; fill_line = fl;
      snp_valid = sv; snp_op = so[0]; snp_addr = AW'(sa); snp_wdata = sw;
      #1;
      li = a / NW; lo = a % NW; si = sa / NW; sof = sa % NW;
      e_rd = 0; e_upd = 0; e_fl = 0; e_sh = 0; chk_rsp = 0; e_fd = '0; e_rsp = '0;
      tl = -1; nst = 0;
      if (sv) begin
         tl = si; nst = mst[si];
         for (int k = 0; k < NW; k++) nd[k] = mdat[si][k];
         if (mst[si] != 0) begin
            e_sh = 1;
            if (so == 0) begin
               if (mst[si] == 4 || mst[si] == 3) begin e_fl = 1; e_fd = pack_line(si); nst = 3; end
               if (mst[si] == 1) nst = 2;
            end else begin
               nd[sof] = sw; nst = 2;
            end
         end
      end else if (v) begin
         tl = li; nst = mst[li];
         for (int k = 0; k < NW; k++) nd[k] = mdat[li][k];
         if (op == 0) begin
            chk_rsp = 1;
            if (mst[li] == 0) begin
               e_rd = 1; e_rsp = fl[lo*WW +: WW];
               for (int k = 0; k < NW; k++) nd[k] = fl[k*WW +: WW];
               nst = sh ? 2 : 1;
            end else e_rsp = mdat[li][lo];
         end else if (op == 1) begin
            if (mst[li] == 0) begin
               e_rd = 1;
               for (int k = 0; k < NW; k++) nd[k] = fl[k*WW +: WW];
               e_upd = sh; nst = sh ? 3 : 4;
            end else if (mst[li] == 2 || mst[li] == 3) begin
               e_upd = 1; nst = sh ? 3 : 4;
            end else nst = 4;
            nd[lo] = wd;
         end else if (op == 2) begin
            if (mst[li] == 4 || mst[li] == 3) begin e_fl = 1; e_fd = pack_line(li); end
            nst = 0;
         end
      end
      check(bus_rd == e_rd, tag, "bus_rd", LW'(bus_rd), LW'(e_rd));
      check(bus_upd == e_upd, tag, "bus_upd", LW'(bus_upd), LW'(e_upd));
      check(flush == e_fl, tag, "flush", LW'(flush), LW'(e_fl));
      check(shared_out == e_sh, tag, "shared_out", LW'(shared_out), LW'(e_sh));
      if (e_rd || e_upd) check(bus_addr == AW'(a), tag, "bus_addr", LW'(bus_addr), LW'(a));
      if (e_upd) check(bus_wdata == wd, tag, "bus_wdata", LW'(bus_wdata), LW'(wd));
      if (e_fl) check(flush_data == e_fd, tag, "flush_data", flush_data, e_fd);
      if (chk_rsp) check(rsp_rdata == e_rsp, tag, "rsp_rdata", LW'(rsp_rdata), LW'(e_rsp));
      if (tl >= 0) begin
         mst[tl] = nst;
         for (int k = 0; k < NW; k++) mdat[tl][k] = nd[k];
      end
   endtask

   task automatic req(input int op, input int a, input logic [WW-1:0] wd, input bit sh,
                      input string tag);
      step(1, op, a, wd, sh, 0, 0, 0, '0, tag);
   endtask

   task automatic snp(input int so, input int sa, input logic [WW-1:0] sw, input string tag);
      step(0, 0, 0, '0, $urandom_range(0, 1) == 1, 1, so, sa, sw, tag);
   endtask

   initial begin
      #(5 * 100000);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      rst_n = 0; req_valid = 0; req_op = 0; req_addr = 0; req_wdata = 0;
      fill_line = 0; shared_in = 0; snp_valid = 0; snp_op = 0; snp_addr = 0; snp_wdata = 0;
      for (int i = 0; i < NL; i++) begin
         mst[i] = 0;
         for (int k = 0; k < NW; k++) mdat[i][k] = '0;
      end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;

      step(0, 0, 0, '0, 0, 0, 0, 0, '0, "R1 idle");
      req(0, 4'h0, '0, 0, "R1 R2 miss sole");
      req(0, 4'h1, '0, 0, "R3 hit");
      req(1, 4'h1, 32'h1111_0001, 0, "R5 excl write");
      req(1, 4'h2, 32'h1111_0002, 1, "R5 dirty write");
      snp(0, 4'h0, '0, "R7 dirty snoop");
      snp(0, 4'h3, '0, "R7 owner snoop");
      req(1, 4'h2, 32'h2222_0002, 1, "R6 owner write shared");
      req(1, 4'h3, 32'h2222_0003, 0, "R6 owner write alone");
      snp(0, 4'h0, '0, "R7 dirty again");
      req(0, 4'h4, '0, 1, "R2 miss shared");
      snp(0, 4'h5, '0, "R8 clean snoop");
      req(1, 4'h5, 32'h3333_0005, 1, "R6 clean write");
      snp(1, 4'h6, 32'h4444_0006, "R9 snooped update");
      snp(0, 4'h4, '0, "R9 clean after update");
      req(0, 4'h6, '0, 0, "R9 patched word");
      req(1, 4'h8, 32'h5555_0008, 1, "R4 write miss shared");
      snp(0, 4'h9, '0, "R4 owner flush");
      req(1, 4'hC, 32'h6666_000C, 0, "R4 write miss alone");
      snp(0, 4'hD, '0, "R4 dirty flush");
      req(0, 4'hA, '0, 0, "R3 hit owner");
      req(2, 4'hC, '0, 0, "R12 drop owner");
      snp(0, 4'hC, '0, "R10 R11 empty read snoop");
      snp(1, 4'hE, 32'h7777_000E, "R11 empty update snoop");
      req(0, 4'hC, '0, 0, "R12 refetch after drop");
      req(2, 4'h4, '0, 0, "R12 drop clean");
      req(0, 4'h5, '0, 0, "R12 refetch clean");
      step(1, 1, 4'h0, 32'h8888_0000, 1, 1, 0, 4'h8, '0, "R13 request under snoop");
      snp(0, 4'h0, '0, "R13 data untouched");
      snp(0, 4'hF, '0, "R8 sole to shared");
      req(1, 4'hD, 32'h9999_000D, 0, "R8 write proves shared");
      snp(0, 4'h1, '0, "R10 present");

      for (int n = 0; n < 400; n++) begin
         bit sv;
         sv = ($urandom_range(0, 3) == 0);
         step($urandom_range(0, 4) != 0, $urandom_range(0, 3), $urandom_range(0, 15), $urandom,
              $urandom_range(0, 1) == 1, sv, $urandom_range(0, 1), $urandom_range(0, 15),
              $urandom, sv ? "R13 mixed" : "R10 mixed");
      end

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule